// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block splits a processor bus that reuses its pins over the course of a machine cycle into a plain system bus. Eight shared lines carry the low address byte at the start of each cycle and the data byte later in the same cycle. Eight dedicated lines carry the middle address byte. Four top lines carry the upper address nibble first and status bits afterwards. The block latches a stable 20-bit address, so one million byte locations can be reached. It keeps the status nibble in its own register and steers the data byte in the direction of the current transfer.

The processor side reports its cycle phase through an address strobe, a data-phase flag and a write flag. Two acknowledge inputs mark interrupt-acknowledge and hold-acknowledge cycles. While either acknowledge is present, neither of the block's data drivers is enabled, which leaves both data lanes at high impedance. During hold-acknowledge another master owns the bus, so the latched address is also left untouched. Every tri-state lane is modelled as a data output paired with an output-enable.

Top module: `bus_demux`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), sys_addr, sys_status, sys_wdata and cpu_ad_out are zero and both cpu_ad_oe and sys_wdata_oe are low.
- R2: At a clock edge where ale is high and hold_ack is low, sys_addr takes {cpu_a_top, cpu_a_mid, cpu_ad_in}, with bits 7:0 from cpu_ad_in, bits 15:8 from cpu_a_mid and bits 19:16 from cpu_a_top.
- R3: At a clock edge where ale is low, sys_addr keeps its value.
- R4: At a clock edge where hold_ack is high, ale has no effect and sys_addr keeps its value.
- R5: At a clock edge where data_ph is high and ale is low, sys_status takes cpu_a_top. At any other edge sys_status keeps its value, and it never changes sys_addr.
- R6: After a clock edge, sys_wdata_oe is high exactly when, at that edge, data_ph and wr were high and ale, inta_ack and hold_ack were low. At such an edge sys_wdata takes cpu_ad_in; otherwise sys_wdata keeps its value.
- R7: After a clock edge, cpu_ad_oe is high exactly when, at that edge, data_ph was high and ale, wr, inta_ack and hold_ack were low. At such an edge cpu_ad_out takes sys_rdata; otherwise cpu_ad_out keeps its value.
- R8: cpu_ad_oe and sys_wdata_oe are never high together, and both are low after any edge at which inta_ack or hold_ack was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address strobe, high in the first clock of a cycle |
| data_ph | input | 1 | High while the shared lines carry data |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| inta_ack | input | 1 | Interrupt-acknowledge cycle in progress |
| hold_ack | input | 1 | Bus granted to another master |
| cpu_ad_in | input | 8 | Shared low address / data lines as seen by the block |
| cpu_a_mid | input | 8 | Dedicated address lines, bits 15:8 |
| cpu_a_top | input | 4 | Upper address bits 19:16, later status |
| sys_rdata | input | 8 | Read data from the system bus |
| cpu_ad_out | output | 8 | Read data driven onto the shared lines |
| cpu_ad_oe | output | 1 | Drive enable for the shared lines |
| sys_addr | output | 20 | Latched address |
| sys_status | output | 4 | Latched status nibble |
| sys_wdata | output | 8 | Write data toward the system bus |
| sys_wdata_oe | output | 1 | Drive enable for the system data bus |

## Verification
The bench builds the block with its default widths: 8 shared lines, 8 dedicated lines and 4 top lines. With these widths every one of the 32 combinations of the five phase and acknowledge controls can be swept over many data patterns. A separate sweep drives the address strobe with all 256 low-byte values. Each expected output is worked out from the controls of the previous edge, so the corner cases are covered directly: strobe together with the data flag, strobe during hold, and acknowledge during a data phase.

// File: rtl/bus_demux_pkg.sv
package bus_demux_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ADDR  = 2'd1,
        PH_WDATA = 2'd2,
        PH_RDATA = 2'd3
    } phase_e;

    function automatic phase_e classify(input logic ale, input logic data_ph,
                                        input logic wr, input logic inta,
                                        input logic hold);
        phase_e ph;
        ph = PH_IDLE;
        if (ale) begin
            if (!hold) ph = PH_ADDR;
        end else if (data_ph && !inta && !hold) begin
            ph = wr ? PH_WDATA : PH_RDATA;
        end
        return ph;
    endfunction

endpackage

// File: rtl/bd_phase_decode.sv
module bd_phase_decode
    import bus_demux_pkg::*;
(
    input  logic   ale,
    input  logic   data_ph,
    input  logic   wr,
    input  logic   inta_ack,
    input  logic   hold_ack,
    output phase_e phase,
    output logic   stat_en
);
    always_comb begin
        phase   = classify(ale, data_ph, wr, inta_ack, hold_ack);
        stat_en = data_ph & ~ale;
    end
endmodule

// File: rtl/bd_addr_latch.sv
module bd_addr_latch #(
    parameter int LOW_W = 8,
    parameter int MID_W = 8,
    parameter int TOP_W = 4,
    localparam int ADDR_W = LOW_W + MID_W + TOP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LOW_W-1:0]  low_in,
    input  logic [MID_W-1:0]  mid_in,
    input  logic [TOP_W-1:0]  top_in,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) st_d.addr = {top_in, mid_in, low_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr == $past({top_in, mid_in, low_in}));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr));
endmodule

// File: rtl/bd_status_cap.sv
module bd_status_cap #(
    parameter int TOP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [TOP_W-1:0] top_in,
    output logic [TOP_W-1:0] status
);
    typedef struct packed {
        logic [TOP_W-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap) st_d.stat = top_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q.stat;

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> status == $past(top_in));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(status));
endmodule

// File: rtl/bd_data_steer.sv
module bd_data_steer
    import bus_demux_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic [DATA_W-1:0] cpu_din,
    input  logic [DATA_W-1:0] sys_din,
    output logic [DATA_W-1:0] wdata,
    output logic              wdata_oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic              w_oe;
        logic [DATA_W-1:0] rdata;
        logic              r_oe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.w_oe = 1'b0;
        st_d.r_oe = 1'b0;
        case (phase)
            PH_WDATA: begin
                st_d.w_oe  = 1'b1;
                st_d.wdata = cpu_din;
            end
            PH_RDATA: begin
                st_d.r_oe  = 1'b1;
                st_d.rdata = sys_din;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdata    = st_q.wdata;
    assign wdata_oe = st_q.w_oe;
    assign rdata    = st_q.rdata;
    assign rdata_oe = st_q.r_oe;

    a_r6_write_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WDATA) |=> wdata_oe && wdata == $past(cpu_din));
    a_r7_read_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RDATA) |=> rdata_oe && rdata == $past(sys_din));
endmodule

// File: rtl/bus_demux.sv
module bus_demux
    import bus_demux_pkg::*;
#(
    parameter int LOW_W = 8,
    parameter int MID_W = 8,
    parameter int TOP_W = 4,
    localparam int ADDR_W = LOW_W + MID_W + TOP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              data_ph,
    input  logic              wr,
    input  logic              inta_ack,
    input  logic              hold_ack,
    input  logic [LOW_W-1:0]  cpu_ad_in,
    input  logic [MID_W-1:0]  cpu_a_mid,
    input  logic [TOP_W-1:0]  cpu_a_top,
    input  logic [LOW_W-1:0]  sys_rdata,
    output logic [LOW_W-1:0]  cpu_ad_out,
    output logic              cpu_ad_oe,
    output logic [ADDR_W-1:0] sys_addr,
    output logic [TOP_W-1:0]  sys_status,
    output logic [LOW_W-1:0]  sys_wdata,
    output logic              sys_wdata_oe
);
    phase_e phase;
    logic   stat_en;

    bd_phase_decode u_dec (
        .ale(ale), .data_ph(data_ph), .wr(wr),
        .inta_ack(inta_ack), .hold_ack(hold_ack),
        .phase(phase), .stat_en(stat_en)
    );

    bd_addr_latch #(.LOW_W(LOW_W), .MID_W(MID_W), .TOP_W(TOP_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(phase == PH_ADDR),
        .low_in(cpu_ad_in), .mid_in(cpu_a_mid), .top_in(cpu_a_top),
        .addr(sys_addr)
    );

    bd_status_cap #(.TOP_W(TOP_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .cap(stat_en),
        .top_in(cpu_a_top), .status(sys_status)
    );

    bd_data_steer #(.DATA_W(LOW_W)) u_data (
        .clk(clk), .rst_n(rst_n), .phase(phase),
        .cpu_din(cpu_ad_in), .sys_din(sys_rdata),
        .wdata(sys_wdata), .wdata_oe(sys_wdata_oe),
        .rdata(cpu_ad_out), .rdata_oe(cpu_ad_oe)
    );

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ad_oe && sys_wdata_oe));
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_ack || hold_ack) |=> !cpu_ad_oe && !sys_wdata_oe);
    a_r4_hold_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |=> $stable(sys_addr));
endmodule

// File: tb/sim_bus_demux.sv
module sim_bus_demux;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ale = 0, data_ph = 0, wr = 0, inta_ack = 0, hold_ack = 0;
    logic [7:0] cpu_ad_in = 0, cpu_a_mid = 0, sys_rdata = 0;
    logic [3:0] cpu_a_top = 0;
    logic [7:0] cpu_ad_out, sys_wdata;
    logic       cpu_ad_oe, sys_wdata_oe;
    logic [19:0] sys_addr;
    logic [3:0]  sys_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [19:0] e_addr = 0;
    logic [3:0]  e_stat = 0;
    logic [7:0]  e_wd = 0, e_rd = 0;
    logic        e_woe = 0, e_roe = 0;

    always #4 clk = ~clk;

    bus_demux u0 (
        .clk(clk), .rst_n(rst_n), .ale(ale), .data_ph(data_ph), .wr(wr),
        .inta_ack(inta_ack), .hold_ack(hold_ack),
        .cpu_ad_in(cpu_ad_in), .cpu_a_mid(cpu_a_mid), .cpu_a_top(cpu_a_top),
        .sys_rdata(sys_rdata), .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe),
        .sys_addr(sys_addr), .sys_status(sys_status),
        .sys_wdata(sys_wdata), .sys_wdata_oe(sys_wdata_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [4:0] c, input logic [7:0] lo, input logic [7:0] mid,
                        input logic [3:0] top, input logic [7:0] rd);
        ale = c[0]; data_ph = c[1]; wr = c[2]; inta_ack = c[3]; hold_ack = c[4];
        cpu_ad_in = lo; cpu_a_mid = mid; cpu_a_top = top; sys_rdata = rd;
        @(posedge clk);
        if (c[0] && !c[4]) e_addr = {top, mid, lo};
        if (c[1] && !c[0]) e_stat = top;
        e_woe = c[1] && !c[0] && c[2] && !c[3] && !c[4];
        if (e_woe) e_wd = lo;
        e_roe = c[1] && !c[0] && !c[2] && !c[3] && !c[4];
        if (e_roe) e_rd = rd;
        @(negedge clk);
        if (c[0] && c[4])  chk("R4 addr under hold", 32'(sys_addr), 32'(e_addr));
        else if (c[0])     chk("R2 addr capture", 32'(sys_addr), 32'(e_addr));
        else               chk("R3 addr hold", 32'(sys_addr), 32'(e_addr));
        chk("R5 status", 32'(sys_status), 32'(e_stat));
        chk("R6 write lane", {23'd0, sys_wdata_oe, sys_wdata}, {23'd0, e_woe, e_wd});
        chk("R7 read lane", {23'd0, cpu_ad_oe, cpu_ad_out}, {23'd0, e_roe, e_rd});
        chk("R8 exclusive enables", 32'(cpu_ad_oe & sys_wdata_oe), 32'd0);
        if (c[3] || c[4]) chk("R8 ack release", {30'd0, cpu_ad_oe, sys_wdata_oe}, 32'd0);
    endtask

    initial begin
        cpu_ad_in = 8'h5A; cpu_a_mid = 8'hC3; cpu_a_top = 4'hF; sys_rdata = 8'h99;
        ale = 1; data_ph = 1; wr = 1;
        repeat (3) @(negedge clk);
        // R1: reset state with busy inputs
        chk("R1 reset addr", 32'(sys_addr), 32'd0);
        chk("R1 reset status", 32'(sys_status), 32'd0);
        chk("R1 reset data/enables",
            {14'd0, cpu_ad_oe, sys_wdata_oe, cpu_ad_out, sys_wdata}, 32'd0);
        rst_n = 1'b1;
        ale = 0; data_ph = 0; wr = 0;
        @(negedge clk);
        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 16; k++) begin
                step(5'(c), 8'(k * 17 + c * 3 + 1), 8'(k * 29 ^ c), 4'(k + c),
                     8'(255 - k * 13 - c));
            end
        end
        // exhaustive low-byte address sweep, each followed by a write and a read
        for (int v = 0; v < 256; v++) begin
            step(5'b00001, 8'(v), 8'(v ^ 8'hA5), 4'(v >> 4), 8'(v));
            step(5'b00110, 8'(~v), 8'(v), 4'(v), 8'(v + 1));
            step(5'b00010, 8'(v + 7), 8'(v), 4'(~v), 8'(v * 3));
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule